// File: doc/BRIEF.md
# Store Issue Ordering Checker

This block decides what happens to a store at the moment it issues against a circular load/store queue. It looks back through the entries that are older than the store and picks the nearest older store that could write the same 8-byte chunk. That older store becomes the dependency, and the lookup also decides whether the issuing store may finish now or must wait and be replayed. It then looks forward through the younger entries for a load that has already issued to the same chunk. Such a load read stale data.

The queue state is presented as flat per-entry field vectors, together with the head index, the occupancy and the slot of the issuing store. A short list of load chunks handled in the same cycle is also supplied. The verdict is computed combinationally and registered once. The result therefore appears on the cycle after the request. When a misspeculation is found, the identifier of the offending load is returned so that an alias predictor can learn from it. Annulment of younger work is left to other logic.

Top module: `store_order_check`

## Requirements
- R1: After reset, and on every cycle that follows a cycle with `reqValid` low, `resValid`, `depValid`, `secondPhase` and `aliasValid` are 0 and `verdict` is 2'b00 (idle). A request sampled at one rising edge produces its result on the outputs after that same edge, so the outputs are valid during the following cycle.
- R2: The older lookup visits slots `storeIdx-1`, `storeIdx-2`, ... down to `headIdx`, nearest first. It skips entries whose store flag is 0. The first store with a valid address and a chunk equal to `storeChunk` is the dependency, and `depIdx` gives its slot.
- R3: An older store with a valid address and either fence flag set is never the dependency, even when its chunk is equal. The lookup continues past it.
- R4: An older store whose address is not valid is the dependency, whatever its chunk. The exception is an entry with the load-fence flag set and the store-fence flag clear: that entry is skipped.
- R5: The store is ready when its own `storeDataReady` is 1 and either no dependency was found or the dependency has both address and data valid. A store that is not ready gets `verdict` = 2'b10 (replay) with `secondPhase` = 1. A ready store with no alias gets `verdict` = 2'b01 (complete).
- R6: When the store is ready, the younger lookup visits slots `storeIdx+1` upward within the occupancy. It flags the nearest entry whose store flag is 0, whose address is valid, whose issued flag is 1 and whose chunk is equal. Such a flag gives `verdict` = 2'b11 (misspeculated), `aliasValid` = 1 and `aliasId` = that entry's identifier.
- R7: When a flagged younger load exists and some valid entry of the same-cycle list equals `storeChunk`, the verdict is 2'b10 (replay). In that case `secondPhase` = 0 and `aliasValid` = 0.
- R8: Slot arithmetic wraps modulo the queue depth. Entries outside the occupied range from `headIdx` through `headIdx+count-1` never take part in either lookup.
- R9: A store that is not ready is replayed without a younger lookup. `aliasValid` stays 0 even when an aliased younger load exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A store issues this cycle |
| headIdx | input | IDXW | Slot of the oldest queue entry |
| count | input | IDXW+1 | Number of occupied entries |
| storeIdx | input | IDXW | Slot of the issuing store |
| storeChunk | input | AW | Chunk address of the issuing store |
| storeDataReady | input | 1 | Data of the issuing store is available |
| entIsStore | input | QDEPTH | Per-entry store flag |
| entAddrValid | input | QDEPTH | Per-entry address valid |
| entDataValid | input | QDEPTH | Per-entry data valid |
| entLoadFence | input | QDEPTH | Per-entry load fence flag |
| entStoreFence | input | QDEPTH | Per-entry store fence flag |
| entIssued | input | QDEPTH | Per-entry issued flag |
| entChunk | input | QDEPTH*AW | Per-entry chunk address, slot i at bits [i*AW +: AW] |
| entId | input | QDEPTH*IDW | Per-entry identifier, slot i at bits [i*IDW +: IDW] |
| parValid | input | NPAR | Valid flags of the same-cycle load list |
| parChunk | input | NPAR*AW | Same-cycle load chunks, item j at bits [j*AW +: AW] |
| resValid | output | 1 | A registered result is present |
| verdict | output | 2 | 00 idle, 01 complete, 10 replay, 11 misspeculated |
| depValid | output | 1 | An older dependency was found |
| depIdx | output | IDXW | Slot of the dependency |
| secondPhase | output | 1 | Replay caused by readiness |
| aliasValid | output | 1 | A misspeculating younger load was found |
| aliasId | output | IDW | Identifier of that load |

## Verification
Two decisions can land in one issue: the readiness decision from the older lookup, and the alias decision from the younger lookup. The bench builds queue images in which an unready dependency and an issued, aliasing younger load are both present. It checks that the readiness replay wins and that no alias is reported. It also builds images with an alias and a matching same-cycle list entry, and checks that these replay without the second-phase mark. Random images with small chunk ranges make both collisions frequent. Every result is compared with an independent slot-by-slot model in the bench.

// File: rtl/store_order_pkg.sv
package store_order_pkg;

  typedef enum logic [1:0] {
    VERD_IDLE    = 2'b00,
    VERD_DONE    = 2'b01,
    VERD_REPLAY  = 2'b10,
    VERD_MISSPEC = 2'b11
  } verdict_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic     capture;
    logic     depValid;
    logic     aliasValid;
    logic     secondPhase;
    verdict_e verdict;
  } ctrl_strobe_t;

endpackage

// File: rtl/store_order_dp.sv
module store_order_dp
  import store_order_pkg::*;
#(
  parameter int QDEPTH = 8,
  parameter int AW     = 12,
  parameter int IDW    = 6,
  parameter int NPAR   = 2,
  localparam int IDXW  = $clog2(QDEPTH),
  localparam int NOFF  = QDEPTH - 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [IDXW-1:0]        headIdx,
  input  logic [IDXW:0]          count,
  input  logic [IDXW-1:0]        storeIdx,
  input  logic [AW-1:0]          storeChunk,
  input  logic [QDEPTH-1:0]      entIsStore,
  input  logic [QDEPTH-1:0]      entAddrValid,
  input  logic [QDEPTH-1:0]      entDataValid,
  input  logic [QDEPTH-1:0]      entLoadFence,
  input  logic [QDEPTH-1:0]      entStoreFence,
  input  logic [QDEPTH-1:0]      entIssued,
  input  logic [QDEPTH*AW-1:0]   entChunk,
  input  logic [QDEPTH*IDW-1:0]  entId,
  input  logic [NPAR-1:0]        parValid,
  input  logic [NPAR*AW-1:0]     parChunk,
  // Per-offset lookup results (bit j is offset j+1)
  output logic [NOFF-1:0]        olderHit,
  output logic [NOFF-1:0]        olderBoth,
  output logic [NOFF-1:0]        youngerHit,
  output logic                   parHit,
  // From control
  input  ctrl_strobe_t           strobe,
  input  logic [NOFF-1:0]        depSel,
  input  logic [NOFF-1:0]        aliasSel,
  // Registered result
  output logic                   resValid,
  output verdict_e               verdict,
  output logic                   depValid,
  output logic [IDXW-1:0]        depIdx,
  output logic                   secondPhase,
  output logic                   aliasValid,
  output logic [IDW-1:0]         aliasId
);

  logic [IDXW-1:0] olderCnt;
  logic [IDXW:0]   olderCntWide;
  logic [IDXW:0]   youngerCnt;

  always_comb begin
    olderCnt     = storeIdx - headIdx;
    olderCntWide = {1'b0, olderCnt};
    if (count > olderCntWide) youngerCnt = count - olderCntWide - 1'b1;
    else                      youngerCnt = '0;
  end

  logic [IDXW-1:0] olderSlot   [NOFF];
  logic [IDXW-1:0] youngerSlot [NOFF];

  for (genvar j = 0; j < NOFF; j++) begin : g_off
    localparam int K = j + 1;
    logic [IDXW-1:0] oS;
    logic [IDXW-1:0] yS;
    logic            oIn;
    logic            yIn;
    logic            oSkip;
    logic            oEq;
    logic            yEq;

    assign oS  = storeIdx - IDXW'(K);
    assign yS  = storeIdx + IDXW'(K);
    assign oIn = (IDXW+1)'(K) <= olderCntWide;
    assign yIn = (IDXW+1)'(K) <= youngerCnt;
    assign oEq = entChunk[oS*AW +: AW] == storeChunk;
    assign yEq = entChunk[yS*AW +: AW] == storeChunk;

    // Loads, resolved fences and unresolved load-only fences are passed over
    assign oSkip = !entIsStore[oS]
                 || (entAddrValid[oS] && (entLoadFence[oS] || entStoreFence[oS]))
                 || (!entAddrValid[oS] && entLoadFence[oS] && !entStoreFence[oS]);

    assign olderHit[j]   = oIn && !oSkip && (!entAddrValid[oS] || oEq);
    assign olderBoth[j]  = entAddrValid[oS] && entDataValid[oS];
    assign youngerHit[j] = yIn && !entIsStore[yS] && entAddrValid[yS]
                         && entIssued[yS] && yEq;
    assign olderSlot[j]   = oS;
    assign youngerSlot[j] = yS;
  end

  always_comb begin
    parHit = 1'b0;
    for (int p = 0; p < NPAR; p++) begin
      if (parValid[p] && (parChunk[p*AW +: AW] == storeChunk)) parHit = 1'b1;
    end
  end

  // Turn one-hot selects into slot and identifier
  logic [IDXW-1:0] depIdxNext;
  logic [IDW-1:0]  aliasIdNext;

  always_comb begin
    depIdxNext  = '0;
    aliasIdNext = '0;
    for (int j = 0; j < NOFF; j++) begin
      if (depSel[j])   depIdxNext  = depIdxNext | olderSlot[j];
      if (aliasSel[j]) aliasIdNext = aliasIdNext | entId[youngerSlot[j]*IDW +: IDW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid    <= 1'b0;
      verdict     <= VERD_IDLE;
      depValid    <= 1'b0;
      depIdx      <= '0;
      secondPhase <= 1'b0;
      aliasValid  <= 1'b0;
      aliasId     <= '0;
    end else begin
      resValid    <= strobe.capture;
      verdict     <= strobe.verdict;
      depValid    <= strobe.depValid;
      depIdx      <= strobe.depValid ? depIdxNext : '0;
      secondPhase <= strobe.secondPhase;
      aliasValid  <= strobe.aliasValid;
      aliasId     <= strobe.aliasValid ? aliasIdNext : '0;
    end
  end

endmodule

// File: rtl/store_order_ctrl.sv
module store_order_ctrl
  import store_order_pkg::*;
#(
  parameter int QDEPTH = 8,
  localparam int NOFF  = QDEPTH - 1
) (
  input  logic            reqValid,
  input  logic            storeDataReady,
  input  logic [NOFF-1:0] olderHit,
  input  logic [NOFF-1:0] olderBoth,
  input  logic [NOFF-1:0] youngerHit,
  input  logic            parHit,
  output ctrl_strobe_t    strobe,
  output logic [NOFF-1:0] depSel,
  output logic [NOFF-1:0] aliasSel
);

  logic [NOFF-1:0] depOh;
  logic [NOFF-1:0] aliasOh;
  logic            anyDep;
  logic            anyAlias;
  logic            depBoth;
  logic            isReady;

  always_comb begin
    // Lowest offset wins: nearest entry in each direction
    depOh    = olderHit & (~olderHit + 1'b1);
    aliasOh  = youngerHit & (~youngerHit + 1'b1);
    anyDep   = |olderHit;
    anyAlias = |youngerHit;
    depBoth  = |(depOh & olderBoth);
    isReady  = storeDataReady && (!anyDep || depBoth);

    strobe.capture     = reqValid;
    strobe.depValid    = reqValid && anyDep;
    strobe.aliasValid  = 1'b0;
    strobe.secondPhase = 1'b0;
    strobe.verdict     = VERD_IDLE;
    depSel             = depOh;
    aliasSel           = '0;

    if (reqValid) begin
      if (!isReady) begin
        strobe.verdict     = VERD_REPLAY;
        strobe.secondPhase = 1'b1;
      end else if (anyAlias && parHit) begin
        strobe.verdict = VERD_REPLAY;
      end else if (anyAlias) begin
        strobe.verdict    = VERD_MISSPEC;
        strobe.aliasValid = 1'b1;
        aliasSel          = aliasOh;
      end else begin
        strobe.verdict = VERD_DONE;
      end
    end
  end

endmodule

// File: rtl/store_order_check.sv
module store_order_check
  import store_order_pkg::*;
#(
  parameter int QDEPTH = 8,
  parameter int AW     = 12,
  parameter int IDW    = 6,
  parameter int NPAR   = 2,
  localparam int IDXW  = $clog2(QDEPTH),
  localparam int NOFF  = QDEPTH - 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [IDXW-1:0]       headIdx,
  input  logic [IDXW:0]         count,
  input  logic [IDXW-1:0]       storeIdx,
  input  logic [AW-1:0]         storeChunk,
  input  logic                  storeDataReady,
  input  logic [QDEPTH-1:0]     entIsStore,
  input  logic [QDEPTH-1:0]     entAddrValid,
  input  logic [QDEPTH-1:0]     entDataValid,
  input  logic [QDEPTH-1:0]     entLoadFence,
  input  logic [QDEPTH-1:0]     entStoreFence,
  input  logic [QDEPTH-1:0]     entIssued,
  input  logic [QDEPTH*AW-1:0]  entChunk,
  input  logic [QDEPTH*IDW-1:0] entId,
  input  logic [NPAR-1:0]       parValid,
  input  logic [NPAR*AW-1:0]    parChunk,
  output logic                  resValid,
  output logic [1:0]            verdict,
  output logic                  depValid,
  output logic [IDXW-1:0]       depIdx,
  output logic                  secondPhase,
  output logic                  aliasValid,
  output logic [IDW-1:0]        aliasId
);

  logic [NOFF-1:0] olderHit;
  logic [NOFF-1:0] olderBoth;
  logic [NOFF-1:0] youngerHit;
  logic            parHit;
  ctrl_strobe_t    strobe;
  logic [NOFF-1:0] depSel;
  logic [NOFF-1:0] aliasSel;
  verdict_e        verdictQ;

  store_order_ctrl #(.QDEPTH(QDEPTH)) u_ctrl (
    .reqValid       (reqValid),
    .storeDataReady (storeDataReady),
    .olderHit       (olderHit),
    .olderBoth      (olderBoth),
    .youngerHit     (youngerHit),
    .parHit         (parHit),
    .strobe         (strobe),
    .depSel         (depSel),
    .aliasSel       (aliasSel)
  );

  store_order_dp #(.QDEPTH(QDEPTH), .AW(AW), .IDW(IDW), .NPAR(NPAR)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .headIdx       (headIdx),
    .count         (count),
    .storeIdx      (storeIdx),
    .storeChunk    (storeChunk),
    .entIsStore    (entIsStore),
    .entAddrValid  (entAddrValid),
    .entDataValid  (entDataValid),
    .entLoadFence  (entLoadFence),
    .entStoreFence (entStoreFence),
    .entIssued     (entIssued),
    .entChunk      (entChunk),
    .entId         (entId),
    .parValid      (parValid),
    .parChunk      (parChunk),
    .olderHit      (olderHit),
    .olderBoth     (olderBoth),
    .youngerHit    (youngerHit),
    .parHit        (parHit),
    .strobe        (strobe),
    .depSel        (depSel),
    .aliasSel      (aliasSel),
    .resValid      (resValid),
    .verdict       (verdictQ),
    .depValid      (depValid),
    .depIdx        (depIdx),
    .secondPhase   (secondPhase),
    .aliasValid    (aliasValid),
    .aliasId       (aliasId)
  );

  assign verdict = verdictQ;

endmodule

// File: rtl/store_order_sva.sv
module store_order_sva #(
  parameter int IDW = 6
) (
  input logic           clk,
  input logic           rstN,
  input logic           reqValid,
  input logic           resValid,
  input logic [1:0]     verdict,
  input logic           depValid,
  input logic           secondPhase,
  input logic           aliasValid,
  input logic [IDW-1:0] aliasId
);

  // R1
  result_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> resValid);

  // R1
  idle_after_no_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!resValid && verdict == 2'b00 && !depValid && !aliasValid && !secondPhase));

  // R5
  second_phase_is_replay_chk: assert property (@(posedge clk) disable iff (!rstN)
    secondPhase |-> verdict == 2'b10);

  // R5
  complete_is_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    (verdict == 2'b01) |-> (!secondPhase && !aliasValid));

  // R6
  alias_iff_misspec_chk: assert property (@(posedge clk) disable iff (!rstN)
    aliasValid == (verdict == 2'b11));

  // R7
  no_alias_id_on_replay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (verdict == 2'b10) |-> (!aliasValid && aliasId == '0));

  // R9
  not_ready_hides_alias_chk: assert property (@(posedge clk) disable iff (!rstN)
    secondPhase |-> !aliasValid);

endmodule

bind store_order_check store_order_sva #(.IDW(IDW)) u_sva (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .resValid    (resValid),
  .verdict     (verdict),
  .depValid    (depValid),
  .secondPhase (secondPhase),
  .aliasValid  (aliasValid),
  .aliasId     (aliasId)
);

// File: tb/tb_store_order_check.sv
module tb_store_order_check;

  localparam int Q    = 8;
  localparam int AW   = 12;
  localparam int IDW  = 6;
  localparam int NPAR = 2;
  localparam int IDXW = $clog2(Q);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic            reqValid = 1'b0;
  logic [IDXW-1:0] headIdx = '0;
  logic [IDXW:0]   count = '0;
  logic [IDXW-1:0] storeIdx = '0;
  logic [AW-1:0]   storeChunk = '0;
  logic            storeDataReady = 1'b0;
  logic            bSt [Q];
  logic            bAv [Q];
  logic            bDv [Q];
  logic            bLf [Q];
  logic            bSf [Q];
  logic            bIs [Q];
  logic [AW-1:0]   bCh [Q];
  logic [IDW-1:0]  bId [Q];
  logic            bPv [NPAR];
  logic [AW-1:0]   bPc [NPAR];

  logic [Q-1:0]      entIsStore, entAddrValid, entDataValid, entLoadFence, entStoreFence, entIssued;
  logic [Q*AW-1:0]   entChunk;
  logic [Q*IDW-1:0]  entId;
  logic [NPAR-1:0]   parValid;
  logic [NPAR*AW-1:0] parChunk;

  always_comb begin
    for (int i = 0; i < Q; i++) begin
      entIsStore[i]    = bSt[i];
      entAddrValid[i]  = bAv[i];
      entDataValid[i]  = bDv[i];
      entLoadFence[i]  = bLf[i];
      entStoreFence[i] = bSf[i];
      entIssued[i]     = bIs[i];
      entChunk[i*AW +: AW]  = bCh[i];
      entId[i*IDW +: IDW]   = bId[i];
    end
    for (int p = 0; p < NPAR; p++) begin
      parValid[p] = bPv[p];
      parChunk[p*AW +: AW] = bPc[p];
    end
  end

  logic            resValid;
  logic [1:0]      verdict;
  logic            depValid;
  logic [IDXW-1:0] depIdx;
  logic            secondPhase;
  logic            aliasValid;
  logic [IDW-1:0]  aliasId;

  store_order_check #(.QDEPTH(Q), .AW(AW), .IDW(IDW), .NPAR(NPAR)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .headIdx(headIdx), .count(count),
    .storeIdx(storeIdx), .storeChunk(storeChunk), .storeDataReady(storeDataReady),
    .entIsStore(entIsStore), .entAddrValid(entAddrValid), .entDataValid(entDataValid),
    .entLoadFence(entLoadFence), .entStoreFence(entStoreFence), .entIssued(entIssued),
    .entChunk(entChunk), .entId(entId), .parValid(parValid), .parChunk(parChunk),
    .resValid(resValid), .verdict(verdict), .depValid(depValid), .depIdx(depIdx),
    .secondPhase(secondPhase), .aliasValid(aliasValid), .aliasId(aliasId)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Expected values
  int eVer, eDepV, eDepIdx, eSec, eAlV, eAlId;

  task automatic model();
    int older, younger, dep, ali, s;
    bit rdy, par;
    older   = (int'(storeIdx) - int'(headIdx) + Q) % Q;
    younger = int'(count) - older - 1;
    dep = -1;
    for (int k = 1; k <= older; k++) begin
      s = (int'(storeIdx) - k + Q) % Q;
      if (!bSt[s]) continue;
      if (bAv[s]) begin
        if (bLf[s] || bSf[s]) continue;
        if (bCh[s] == storeChunk) begin dep = s; break; end
      end else begin
        if (bLf[s] && !bSf[s]) continue;
        dep = s; break;
      end
    end
    rdy = storeDataReady && (dep < 0 || (bAv[dep] && bDv[dep]));
    ali = -1;
    for (int k = 1; k <= younger; k++) begin
      s = (int'(storeIdx) + k) % Q;
      if (!bSt[s] && bAv[s] && bIs[s] && bCh[s] == storeChunk) begin ali = s; break; end
    end
    par = 0;
    for (int p = 0; p < NPAR; p++) if (bPv[p] && bPc[p] == storeChunk) par = 1;
    eDepV = (dep >= 0); eDepIdx = (dep >= 0) ? dep : 0;
    eSec = 0; eAlV = 0; eAlId = 0;
    if (!rdy) begin eVer = 2; eSec = 1; end
    else if (ali >= 0 && par) eVer = 2;
    else if (ali >= 0) begin eVer = 3; eAlV = 1; eAlId = bId[ali]; end
    else eVer = 1;
  endtask

  task automatic clearQ();
    for (int i = 0; i < Q; i++) begin
      bSt[i] = 0; bAv[i] = 1; bDv[i] = 1; bLf[i] = 0; bSf[i] = 0; bIs[i] = 0;
      bCh[i] = AW'(100 + i); bId[i] = IDW'(10 + i);
    end
    for (int p = 0; p < NPAR; p++) begin bPv[p] = 0; bPc[p] = '0; end
    headIdx = 0; count = 6; storeIdx = 4; storeChunk = AW'(7); storeDataReady = 1;
  endtask

  // Drive at negedge, result registered at next posedge, sample at next negedge
  task automatic runReq(string tag);
    reqValid = 1'b1;
    model();
    @(negedge clk);
    chk(tag, "resValid", int'(resValid), 1);
    chk(tag, "verdict", int'(verdict), eVer);
    chk(tag, "depValid", int'(depValid), eDepV);
    if (eDepV != 0) chk(tag, "depIdx", int'(depIdx), eDepIdx);
    chk(tag, "secondPhase", int'(secondPhase), eSec);
    chk(tag, "aliasValid", int'(aliasValid), eAlV);
    if (eAlV != 0) chk(tag, "aliasId", int'(aliasId), eAlId);
  endtask

  initial begin
    #(5ns * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4321));
    clearQ();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "resValid", int'(resValid), 0);
    chk("R1", "verdict", int'(verdict), 0);
    chk("R1", "depValid", int'(depValid), 0);
    chk("R1", "aliasValid", int'(aliasValid), 0);

    // R2: nearest older store with equal chunk; load in between skipped
    clearQ();
    bCh[3] = 7;
    bSt[2] = 1; bCh[2] = 7;
    bSt[1] = 1; bCh[1] = 7;
    runReq("R2");
    chk("R2", "depIdx direct", int'(depIdx), 2);

    // R3: resolved fence with equal chunk skipped
    clearQ();
    bSt[3] = 1; bCh[3] = 7; bSf[3] = 1;
    bSt[2] = 1; bCh[2] = 7;
    runReq("R3");
    chk("R3", "depIdx direct", int'(depIdx), 2);

    // R4: unresolved load-only fence skipped, unresolved store matches
    clearQ();
    bSt[3] = 1; bAv[3] = 0; bLf[3] = 1;
    bSt[2] = 1; bAv[2] = 0; bCh[2] = 55;
    runReq("R4");
    chk("R4", "depIdx direct", int'(depIdx), 2);

    // R5: dependency without data -> replay
    clearQ();
    bSt[2] = 1; bCh[2] = 7; bDv[2] = 0;
    runReq("R5");
    chk("R5", "verdict direct", int'(verdict), 2);
    // R5: own data not ready
    clearQ();
    storeDataReady = 0;
    runReq("R5");
    // R5: ready, complete
    clearQ();
    runReq("R5");
    chk("R5", "verdict complete", int'(verdict), 1);

    // R6: younger issued load aliases
    clearQ();
    bIs[5] = 1; bCh[5] = 7; bId[5] = 6'd33;
    runReq("R6");
    chk("R6", "aliasId direct", int'(aliasId), 33);

    // R7: same-cycle list turns it into a replay
    clearQ();
    bIs[5] = 1; bCh[5] = 7;
    bPv[1] = 1; bPc[1] = 7;
    runReq("R7");
    chk("R7", "verdict direct", int'(verdict), 2);
    chk("R7", "secondPhase direct", int'(secondPhase), 0);

    // R8: wraparound, entries outside occupancy ignored
    clearQ();
    headIdx = 6; count = 6; storeIdx = 1;
    bSt[5] = 1; bAv[5] = 0;
    bIs[4] = 1; bCh[4] = 7;
    bSt[7] = 1; bCh[7] = 7;
    runReq("R8");
    chk("R8", "depIdx direct", int'(depIdx), 7);
    chk("R8", "verdict direct", int'(verdict), 1);

    // R9: not ready plus alias -> replay, no alias report
    clearQ();
    bSt[2] = 1; bAv[2] = 0;
    bIs[5] = 1; bCh[5] = 7;
    runReq("R9");
    chk("R9", "aliasValid direct", int'(aliasValid), 0);

    // Random images
    for (int t = 0; t < 400; t++) begin
      @(negedge clk);
      for (int i = 0; i < Q; i++) begin
        bSt[i] = $urandom_range(1);
        bAv[i] = ($urandom_range(3) != 0);
        bDv[i] = $urandom_range(1);
        bLf[i] = ($urandom_range(5) == 0);
        bSf[i] = ($urandom_range(5) == 0);
        bIs[i] = $urandom_range(1);
        bCh[i] = AW'($urandom_range(3));
        bId[i] = IDW'($urandom_range(63));
      end
      for (int p = 0; p < NPAR; p++) begin
        bPv[p] = ($urandom_range(3) == 0);
        bPc[p] = AW'($urandom_range(3));
      end
      headIdx = IDXW'($urandom_range(Q - 1));
      count = (IDXW+1)'($urandom_range(Q, 1));
      storeIdx = headIdx + IDXW'($urandom_range(int'(count) - 1));
      storeChunk = AW'($urandom_range(3));
      storeDataReady = ($urandom_range(4) != 0);
      reqValid = 1'b1;
      model();
      @(negedge clk);
      chk("R8", "rand verdict", int'(verdict), eVer);
      chk("R2", "rand depValid", int'(depValid), eDepV);
      if (eDepV != 0) chk("R4", "rand depIdx", int'(depIdx), eDepIdx);
      chk("R5", "rand secondPhase", int'(secondPhase), eSec);
      chk("R6", "rand aliasValid", int'(aliasValid), eAlV);
      if (eAlV != 0) chk("R6", "rand aliasId", int'(aliasId), eAlId);
      if ($urandom_range(3) == 0) begin
        reqValid = 1'b0;
        @(negedge clk);
        chk("R1", "idle resValid", int'(resValid), 0);
        chk("R1", "idle verdict", int'(verdict), 0);
      end
    end

    reqValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1", "final resValid", int'(resValid), 0);
    chk("R1", "final verdict", int'(verdict), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule